// File: doc/BRIEF.md
# SHA-512 Dual-Round Compression Unit

This unit advances a SHA-512 working state by two compression rounds per operation. The eight 64-bit working variables arrive split across two 256-bit vectors. The two per-round words, each already the sum of a message-schedule word and its round constant, arrive packed in one 128-bit vector. The unit returns a 256-bit vector that holds four of the updated variables: a, b, e and f. The caller keeps c, d, g and h from its own copy, because after two rounds they equal the old a, b, e and f.

An operation begins with a one-cycle start pulse, which latches all three operands. The unit computes one round per clock and raises done for a single cycle once the second round has finished. The surrounding logic owns the message schedule, the constant table, the final feed-forward addition and the sequencing over blocks. It issues one operation for each pair of rounds.

Top module: `sha512_dual_round`

## Requirements
- R1: Unpacking uses lanes, where lane k occupies bits [64k+63:64k]. From srcHi: a = lane 3, b = lane 2, e = lane 1, f = lane 0. From srcLo: c = lane 3, d = lane 2, g = lane 1, h = lane 0.
- R2: The first round uses wkPair bits [63:0] and the second round uses wkPair bits [127:64].
- R3: The functions are defined as follows. Sigma on a is the XOR of right rotations by 28, 34 and 39. Sigma on e is the XOR of right rotations by 14, 18 and 41. Choose is (e AND f) XOR (NOT e AND g). Majority is (a AND b) XOR (a AND c) XOR (b AND c).
- R4: Each round forms t1 = choose + sigma(e) + wk + h. The new a is t1 + majority + sigma(a), and the new e is t1 + d. The remaining variables shift: b←a, c←b, d←c, f←e, g←f, h←g.
- R5: The result is packed as lane 3 = a, lane 2 = b, lane 1 = e, lane 0 = f, all taken after the second round.
- R6: Every addition wraps modulo 2^64.
- R7: Suppose a rising edge samples start while the unit is idle. Then done is high for exactly one cycle, starting at the third rising edge after that edge.
- R8: busy is high from the edge that accepts start until done falls. A start sampled while busy is high is ignored: neither the operands nor the result of the operation in flight change.
- R9: A synchronous active-high reset returns the unit to idle with busy and done low and the result at zero.
- R10: While the unit is idle, the result keeps its last value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation when the unit is idle |
| srcLo | input | 256 | Working variables h, g, d, c in lanes 0 to 3 |
| srcHi | input | 256 | Working variables f, e, b, a in lanes 0 to 3 |
| wkPair | input | 128 | Pre-added words: round 0 in the low half, round 1 in the high half |
| busy | output | 1 | High while an operation is in progress, including the done cycle |
| done | output | 1 | One-cycle pulse; the result is valid in this cycle |
| result | output | 256 | Updated f, e, b, a in lanes 0 to 3 |

## Verification
Some properties are checked by assertions on every cycle:
- the lane mapping when operands are latched;
- the shift of the untouched variables in every round;
- the freezing of the state when no strobe is active;
- the single-cycle done pulse and its fixed distance from an accepted start;
- the idle state after reset.

The arithmetic itself is shown only by the bench's scenarios: the rotation amounts, the choose and majority functions, which word half feeds which round, and wrap-around on all-ones operands. The same holds for rejecting a start while busy under back-to-back requests, and for aborting an operation with a reset in flight.

// File: rtl/sha512r_pkg.sv
package sha512r_pkg;

  localparam int WORD_W  = 64;
  localparam int LANES   = 4;
  localparam int VEC_W   = WORD_W * LANES;
  localparam int ROUNDS  = 2;
  localparam int WK_W    = WORD_W * ROUNDS;
  localparam int RIDX_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  // Lane positions shared by unpacking and repacking
  localparam int LANE_A = 3;
  localparam int LANE_B = 2;
  localparam int LANE_E = 1;
  localparam int LANE_F = 0;
  localparam int LANE_C = 3;
  localparam int LANE_D = 2;
  localparam int LANE_G = 1;
  localparam int LANE_H = 0;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
    word_t f;
    word_t g;
    word_t h;
  } wstate_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic              step;
    logic [RIDX_W-1:0] wkSel;
  } strobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } phase_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t sigmaA(input word_t x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic word_t sigmaE(input word_t x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic word_t chooseFn(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t majFn(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

endpackage

// File: rtl/sha512r_round.sv
module sha512r_round
  import sha512r_pkg::*;
(
  input  wstate_t curState,
  input  word_t   wkWord,
  output wstate_t nextState
);

  word_t chVal;
  word_t majVal;
  word_t sigA;
  word_t sigE;
  word_t t1;

  always_comb begin
    chVal  = chooseFn(curState.e, curState.f, curState.g);
    majVal = majFn(curState.a, curState.b, curState.c);
    sigA   = sigmaA(curState.a);
    sigE   = sigmaE(curState.e);
    // Sums wrap naturally at WORD_W bits
    t1     = chVal + sigE + wkWord + curState.h;

    nextState.a = t1 + majVal + sigA;
    nextState.b = curState.a;
    nextState.c = curState.b;
    nextState.d = curState.c;
    nextState.e = t1 + curState.d;
    nextState.f = curState.e;
    nextState.g = curState.f;
    nextState.h = curState.g;
  end

endmodule

// File: rtl/sha512r_ctrl.sv
module sha512r_ctrl
  import sha512r_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  output strobes_t strb,
  output logic     busy,
  output logic     done
);

  phase_t            phaseQ;
  logic [RIDX_W-1:0] roundQ;
  logic              lastRound;

  assign lastRound = (roundQ == RIDX_W'(ROUNDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= ST_IDLE;
      roundQ <= '0;
    end else begin
      unique case (phaseQ)
        ST_IDLE: begin
          if (start) begin
            phaseQ <= ST_RUN;
            roundQ <= '0;
          end
        end
        ST_RUN: begin
          if (lastRound) begin
            phaseQ <= ST_FIN;
            roundQ <= '0;
          end else begin
            roundQ <= roundQ + 1'b1;
          end
        end
        ST_FIN:  phaseQ <= ST_IDLE;
        default: phaseQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load  = (phaseQ == ST_IDLE) && start;
    strb.step  = (phaseQ == ST_RUN);
    strb.wkSel = roundQ;
  end

  assign busy = (phaseQ != ST_IDLE);
  assign done = (phaseQ == ST_FIN);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                   // R7
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start && !busy, 3));                // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);                        // R8
  AST_LOAD_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
    strb.load |-> !busy && !strb.step);                // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy && !done));                         // R9

endmodule

// File: rtl/sha512r_datapath.sv
module sha512r_datapath
  import sha512r_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strb,
  input  logic [VEC_W-1:0]   srcLo,
  input  logic [VEC_W-1:0]   srcHi,
  input  logic [WK_W-1:0]    wkPair,
  output logic [VEC_W-1:0]   result
);

  word_t loLane [LANES];
  word_t hiLane [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign loLane[k] = srcLo[k*WORD_W +: WORD_W];
    assign hiLane[k] = srcHi[k*WORD_W +: WORD_W];
  end

  wstate_t                        stateQ;
  logic [ROUNDS-1:0][WORD_W-1:0]  wkQ;
  wstate_t                        unpacked;
  wstate_t                        stepped;
  word_t                          wkWord;

  always_comb begin
    unpacked.a = hiLane[LANE_A];
    unpacked.b = hiLane[LANE_B];
    unpacked.e = hiLane[LANE_E];
    unpacked.f = hiLane[LANE_F];
    unpacked.c = loLane[LANE_C];
    unpacked.d = loLane[LANE_D];
    unpacked.g = loLane[LANE_G];
    unpacked.h = loLane[LANE_H];
  end

  assign wkWord = wkQ[strb.wkSel];

  sha512r_round u_round (
    .curState  (stateQ),
    .wkWord    (wkWord),
    .nextState (stepped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= '0;
      wkQ    <= '0;
    end else if (strb.load) begin
      stateQ <= unpacked;
      wkQ    <= wkPair;
    end else if (strb.step) begin
      stateQ <= stepped;
    end
  end

  always_comb begin
    result = '0;
    result[LANE_A*WORD_W +: WORD_W] = stateQ.a;
    result[LANE_B*WORD_W +: WORD_W] = stateQ.b;
    result[LANE_E*WORD_W +: WORD_W] = stateQ.e;
    result[LANE_F*WORD_W +: WORD_W] = stateQ.f;
  end

  AST_LOAD_MAP: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (stateQ.a == $past(srcHi[255:192]) && stateQ.h == $past(srcLo[63:0])
                   && stateQ.e == $past(srcHi[127:64]) && stateQ.c == $past(srcLo[255:192]))); // R1
  AST_ROUND_SHIFT: assert property (@(posedge clk) disable iff (rst)
    strb.step |=> (stateQ.b == $past(stateQ.a) && stateQ.c == $past(stateQ.b)
                   && stateQ.f == $past(stateQ.e) && stateQ.h == $past(stateQ.g)));            // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && !strb.step) |=> $stable(result));   // R10

endmodule

// File: rtl/sha512_dual_round.sv
module sha512_dual_round
  import sha512r_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [VEC_W-1:0]   srcLo,
  input  logic [VEC_W-1:0]   srcHi,
  input  logic [WK_W-1:0]    wkPair,
  output logic               busy,
  output logic               done,
  output logic [VEC_W-1:0]   result
);

  strobes_t strb;

  sha512r_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  sha512r_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .srcLo  (srcLo),
    .srcHi  (srcHi),
    .wkPair (wkPair),
    .result (result)
  );

endmodule

// File: tb/sha512_dual_round_tb_top.sv
module sha512_dual_round_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [255:0] srcLo;
  logic [255:0] srcHi;
  logic [127:0] wkPair;
  logic         busy;
  logic         done;
  logic [255:0] result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha512_dual_round dut_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .srcLo  (srcLo),
    .srcHi  (srcHi),
    .wkPair (wkPair),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction

  function automatic logic [255:0] refCompute(input logic [255:0] lo,
                                              input logic [255:0] hi,
                                              input logic [127:0] wk);
    logic [63:0] v [8];  // a b c d e f g h
    v[0] = hi[255:192]; v[1] = hi[191:128];
    v[2] = lo[255:192]; v[3] = lo[191:128];
    v[4] = hi[127:64];  v[5] = hi[63:0];
    v[6] = lo[127:64];  v[7] = lo[63:0];
    for (int r = 0; r < 2; r++) begin
      logic [63:0] w, s0, s1, ch, mj, t1;
      w  = wk[r*64 +: 64];
      s0 = rr(v[0], 28) ^ rr(v[0], 34) ^ rr(v[0], 39);
      s1 = rr(v[4], 14) ^ rr(v[4], 18) ^ rr(v[4], 41);
      ch = v[6] ^ (v[4] & (v[5] ^ v[6]));
      mj = (v[0] & v[1]) | (v[2] & (v[0] | v[1]));
      t1 = ch + s1 + w + v[7];
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + mj + s0;
    end
    return {v[0], v[1], v[4], v[5]};
  endfunction

  // ---------------- cycle model ----------------
  int           phase = 0;
  logic [255:0] expRes = '0;
  bit           modelLive = 0;

  always @(posedge clk) begin
    if (rst) begin
      phase     = 0;
      expRes    = '0;
      modelLive = 1;
    end else if (phase == 0) begin
      if (start) begin
        phase  = 1;
        expRes = refCompute(srcLo, srcHi, wkPair);
      end
    end else if (phase == 3) begin
      phase = 0;
    end else begin
      phase = phase + 1;
    end
  end

  always @(negedge clk) begin
    if (modelLive) begin
      checks++;
      if (busy !== (phase != 0)) begin
        errors++;
        $display("FAIL R8 busy: actual %b expected %b", busy, (phase != 0));
      end
      checks++;
      if (done !== (phase == 3)) begin
        errors++;
        $display("FAIL R7 done: actual %b expected %b", done, (phase == 3));
      end
      if (phase == 0 || phase == 3) begin
        checks++;
        if (result !== expRes) begin
          errors++;
          $display("FAIL R5 R10 result: actual %h expected %h", result, expRes);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL R7 watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic checkVal(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runOp(input string tag, input logic [255:0] lo,
                       input logic [255:0] hi, input logic [127:0] wk);
    logic [255:0] exp;
    int n;
    exp = refCompute(lo, hi, wk);
    @(negedge clk);
    srcLo = lo; srcHi = hi; wkPair = wk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 10) begin
      @(negedge clk);
      n++;
    end
    checkVal(tag, result, exp);
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [255:0] lo0, hi0, exp0;
    logic [127:0] wk0;
    rst = 1'b1; start = 1'b0; srcLo = '0; srcHi = '0; wkPair = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    checkVal("R9 reset busy", {255'd0, busy}, '0);
    checkVal("R9 reset done", {255'd0, done}, '0);
    checkVal("R9 reset result", result, '0);

    // R1: distinct lane values, zero wk
    runOp("R1 lane unpack",
          {64'd41, 64'd42, 64'd43, 64'd44}, {64'd71, 64'd72, 64'd73, 64'd74}, '0);
    // R2: only one word half non-zero at a time
    runOp("R2 round0 word low half", '0, '0, {64'd0, 64'h0123_4567_89ab_cdef});
    runOp("R2 round1 word high half", '0, '0, {64'h0fed_cba9_8765_4321, 64'd0});
    // R3: single-bit states exercise rotations, choose and majority
    runOp("R3 sigma on a", '0, {64'h1, 192'd0}, '0);
    runOp("R3 sigma on e", '0, {128'd0, 64'h8000_0000_0000_0000, 64'd0}, '0);
    runOp("R3 choose select", {128'd0, 64'hAAAA_5555_F0F0_0F0F, 64'd0},
          {128'd0, 64'hFF00_FF00_FF00_FF00, 64'h1234_5678_9abc_def0}, '0);
    runOp("R3 majority", {64'hCCCC_3333_CCCC_3333, 192'd0},
          {64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_00FF_FF00_00FF, 128'd0}, '0);
    // R4 and R5: general patterns
    for (int i = 0; i < 6; i++)
      runOp("R4 R5 random", rnd256(), rnd256(), {$urandom, $urandom, $urandom, $urandom});
    // R6: wrap-around
    runOp("R6 all ones", '1, '1, '1);

    // R8: start held while busy, operands changing; the first op must win
    lo0 = rnd256(); hi0 = rnd256(); wk0 = {$urandom, $urandom, $urandom, $urandom};
    exp0 = refCompute(lo0, hi0, wk0);
    @(negedge clk);
    srcLo = lo0; srcHi = hi0; wkPair = wk0; start = 1'b1;
    @(negedge clk);
    srcLo = rnd256(); srcHi = rnd256(); wkPair = '1;
    @(negedge clk);
    checkVal("R8 busy during op", {255'd0, busy}, 256'd1);
    @(negedge clk);
    checkVal("R8 ignored start result", result, exp0);
    start = 1'b0;
    // let any follow-on op accepted after the done cycle complete
    repeat (5) @(negedge clk);

    // R10: result holds while idle
    runOp("R10 setup", {64'd5, 64'd6, 64'd7, 64'd8}, {64'd1, 64'd2, 64'd3, 64'd4}, {64'd9, 64'd10});
    exp0 = result;
    srcLo = rnd256(); srcHi = rnd256();
    repeat (4) @(negedge clk);
    checkVal("R10 hold idle", result, exp0);

    // R9: reset in flight aborts the operation
    @(negedge clk);
    srcLo = rnd256(); srcHi = rnd256(); start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkVal("R9 abort busy", {255'd0, busy}, '0);
    checkVal("R9 abort result", result, '0);
    repeat (4) @(negedge clk);
    checkVal("R9 no late done", {255'd0, done}, '0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule